// File: doc/BRIEF.md
# Programmable Tapped Digital Delay Line

This block delays a single-bit signal by a programmable number of clock cycles. On every clock edge it samples the input into a shift register. A 7-bit delay code selects which stage of that register drives the outputs. The delay equals a fixed inherent latency plus the code multiplied by a per-step increment. Both the latency and the increment are set when the block is elaborated. Two registered outputs are provided. One is a true copy of the delayed input. The other is an inverted copy whose path is one cycle shorter.

An active-low enable controls both outputs. While the enable is high, the true output is held low, the inverted output is held high and the whole line is cleared. Edges that were in flight are therefore discarded and cannot emerge after the block is enabled again. The delay code is not latched, so the block reads the live code on every cycle.

A guard timer tracks the window during which a change to the code or to the enable could produce spurious pulses. A busy flag is high for the length of that window. A one-cycle error strobe reports any code change made while the window is still open.

Top module: `prog_delay_line`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it is released with the input low, trueOut is 0, invOut is 1, busy is 0 and errStb is 0.
- R2: With the enable low and the code constant at A, an input value sampled at clock edge n appears on trueOut just after edge n + BASE + A*STEP.
- R3: Under the same conditions, the inverse of that input value appears on invOut just after edge n + BASE - 1 + A*STEP.
- R4: If enN is sampled high at a clock edge, then just after that edge trueOut is 0 and invOut is 1.
- R5: Input values sampled before or during a disabled period never reach the outputs once enN returns low.
- R6: When the sampled code rises from old to new, busy is high for exactly (new - old)*STEP cycles, counted from the edge that samples the new code.
- R7: When the sampled code falls, the change by itself does not raise busy.
- R8: When the code changes at an edge while busy is high, errStb is 1 for the one cycle after that edge. A code change while busy is low leaves errStb at 0.
- R9: When enN is first sampled high while the line holds a 1 or the input is high, busy is high for A*STEP cycles. Each further edge that samples the input high while the block is disabled restarts this window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 1 | Signal to be delayed |
| addr | input | ADDR_W | Live delay code |
| enN | input | 1 | Active-low enable |
| trueOut | output | 1 | Delayed copy of the input |
| invOut | output | 1 | Delayed inverted copy of the input |
| busy | output | 1 | High while the hold window is open |
| errStb | output | 1 | One-cycle pulse for a code change made while busy |

## Verification
If the tap index is wrong, a single input pulse shows up on trueOut or invOut at the wrong cycle. The error is visible in the very first pulse measured at a given code, so the bench times pulses at codes from 0 to 127. If a line stage is not cleared during a disable, a ghost pulse appears within BASE + A*STEP cycles after re-enable. If the guard counter is wrong, busy stays high for the wrong number of cycles. That shows on the first widening of the code or the first disable, and errStb then fires, or fails to fire, on the next code change.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic flush;     // clear every line stage
    logic forceOut;  // drive outputs to their idle levels
  } dly_strobe_t;
endpackage

// File: rtl/dly_datapath.sv
module dly_datapath
  import dly_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int STEP   = 2,
  parameter int BASE   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  dly_strobe_t       strb,
  output logic              inFlight,
  output logic              trueOut,
  output logic              invOut
);
  localparam int LEN = BASE + ((1 << ADDR_W) - 1) * STEP;
  localparam int IW  = $clog2(LEN);

  logic [LEN-1:0] line;
  logic [IW-1:0]  tapTrue;
  logic [IW-1:0]  tapInv;

  always_comb begin
    tapTrue = IW'(BASE - 1) + IW'(addr) * IW'(STEP);
    tapInv  = IW'(BASE - 2) + IW'(addr) * IW'(STEP);
  end

  assign inFlight = |line;

  always_ff @(posedge clk) begin
    if (rst || strb.flush) line <= '0;
    else                   line <= {line[LEN-2:0], dataIn};
  end

  always_ff @(posedge clk) begin
    if (rst || strb.forceOut) begin
      trueOut <= 1'b0;
      invOut  <= 1'b1;
    end else begin
      trueOut <= line[tapTrue];
      invOut  <= ~line[tapInv];
    end
  end
endmodule

// File: rtl/dly_control.sv
module dly_control
  import dly_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int STEP   = 2,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enN,
  input  logic              inFlight,
  output dly_strobe_t       strb,
  output logic              busy,
  output logic              errStb
);
  logic [ADDR_W-1:0] addrPrev;
  logic              enPrev;
  logic [CW-1:0]     waitCnt;
  logic [CW-1:0]     loadUp;
  logic [CW-1:0]     loadDis;
  logic [CW-1:0]     loadMax;
  logic [CW-1:0]     decCnt;
  logic [CW-1:0]     nxtCnt;
  logic              addrChg;
  logic              disHit;

  always_comb begin
    addrChg = (addr != addrPrev);
    loadUp  = (addr > addrPrev) ? CW'(addr - addrPrev) * CW'(STEP) : '0;
    disHit  = enN && ((!enPrev && inFlight) || dataIn);
    loadDis = disHit ? CW'(addr) * CW'(STEP) : '0;
    loadMax = (loadUp > loadDis) ? loadUp : loadDis;
    decCnt  = (waitCnt != '0) ? waitCnt - 1'b1 : '0;
    nxtCnt  = (decCnt > loadMax) ? decCnt : loadMax;
    strb.flush    = enN;
    strb.forceOut = enN;
  end

  assign busy = (waitCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrPrev <= '0;
      enPrev   <= 1'b0;
      waitCnt  <= '0;
      errStb   <= 1'b0;
    end else begin
      addrPrev <= addr;
      enPrev   <= enN;
      waitCnt  <= nxtCnt;
      errStb   <= addrChg && busy;
    end
  end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import dly_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int STEP   = 2,
  parameter int BASE   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enN,
  output logic              trueOut,
  output logic              invOut,
  output logic              busy,
  output logic              errStb
);
  localparam int CW = $clog2(((1 << ADDR_W) - 1) * STEP + 1);

  dly_strobe_t strb;
  logic        inFlight;

  dly_control #(.ADDR_W(ADDR_W), .STEP(STEP), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .dataIn(dataIn), .addr(addr), .enN(enN),
    .inFlight(inFlight), .strb(strb), .busy(busy), .errStb(errStb)
  );

  dly_datapath #(.ADDR_W(ADDR_W), .STEP(STEP), .BASE(BASE)) u_dp (
    .clk(clk), .rst(rst), .dataIn(dataIn), .addr(addr), .strb(strb),
    .inFlight(inFlight), .trueOut(trueOut), .invOut(invOut)
  );
endmodule

// File: rtl/dly_checker.sv
module dly_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              enN,
  input logic              trueOut,
  input logic              invOut,
  input logic              busy,
  input logic              errStb
);
  logic [ADDR_W-1:0] lastAddr;
  always_ff @(posedge clk) begin
    if (rst) lastAddr <= '0;
    else     lastAddr <= addr;
  end

  AST_DISABLE_FORCE: assert property (@(posedge clk) disable iff (rst)
    $past(enN) |-> (!trueOut && invOut)); // R4

  AST_REENABLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ($past(enN, 2) && !$past(enN)) |-> (!trueOut && invOut)); // R5

  AST_RISE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (addr > lastAddr) |=> busy); // R6

  AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    errStb |-> $past(busy)); // R8

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    errStb |-> $past(addr) != $past(lastAddr)); // R8
endmodule

bind prog_delay_line dly_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .enN(enN), .trueOut(trueOut),
  .invOut(invOut), .busy(busy), .errStb(errStb)
);

// File: tb/tb_prog_delay_line.sv
module tb_prog_delay_line;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 7;
  localparam int STEP   = 2;
  localparam int BASE   = 3;
  localparam int NVEC   = 5;
  localparam int ADDR_TAB [NVEC] = '{0, 1, 5, 64, 127};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataIn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic enN = 1'b0;
  logic trueOut, invOut, busy, errStb;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_delay_line #(.ADDR_W(ADDR_W), .STEP(STEP), .BASE(BASE)) dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .addr(addr), .enN(enN),
    .trueOut(trueOut), .invOut(invOut), .busy(busy), .errStb(errStb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int tFound, iFound;
    int badCnt;
    repeat (3) @(negedge clk);
    chk(trueOut == 0 && invOut == 1 && !busy && !errStb, "R1 in reset",
        {trueOut, invOut, busy, errStb}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    chk(trueOut == 0 && invOut == 1 && !busy && !errStb, "R1 after reset",
        {trueOut, invOut, busy, errStb}, 4'b0100);

    // Table walk: time one pulse at each code (R2, R3)
    for (int v = 0; v < NVEC; v++) begin
      addr = ADDR_W'(ADDR_TAB[v]);
      @(negedge clk);
      waitIdle();
      dataIn = 1'b1;
      @(negedge clk);
      dataIn = 1'b0;
      tFound = -1;
      iFound = -1;
      for (int d = 0; d < 400; d++) begin
        if (tFound < 0 && trueOut) tFound = d;
        if (iFound < 0 && !invOut) iFound = d;
        if (tFound >= 0 && iFound >= 0) break;
        @(negedge clk);
      end
      chk(tFound == BASE + ADDR_TAB[v] * STEP, "R2 true delay",
          tFound, BASE + ADDR_TAB[v] * STEP);
      chk(iFound == BASE - 1 + ADDR_TAB[v] * STEP, "R3 inverted delay",
          iFound, BASE - 1 + ADDR_TAB[v] * STEP);
      repeat (3) @(negedge clk);
    end

    // R7: 127 -> 4 is a decrease
    addr = 7'd4;
    @(negedge clk);
    chk(!busy, "R7 decrease no busy", busy, 0);
    dataIn = 1'b1;
    repeat (15) @(negedge clk);
    chk(trueOut == 1, "R2 steady high", trueOut, 1);

    // R4/R9: disable while line holds ones
    enN = 1'b1;
    dataIn = 1'b0;
    @(negedge clk);
    chk(trueOut == 0 && invOut == 1, "R4 forced idle", {trueOut, invOut}, 2'b01);
    countBusy(n);
    chk(n == 4 * STEP, "R9 disable window", n, 4 * STEP);
    // R9 restart: input high while disabled
    dataIn = 1'b1;
    @(negedge clk);
    dataIn = 1'b0;
    chk(trueOut == 0 && invOut == 1, "R4 held while disabled", {trueOut, invOut}, 2'b01);
    countBusy(n);
    chk(n == 4 * STEP, "R9 restart window", n, 4 * STEP);

    // R5: re-enable, nothing must emerge
    enN = 1'b0;
    badCnt = 0;
    for (int d = 0; d < 300; d++) begin
      @(negedge clk);
      if (trueOut || !invOut) badCnt++;
    end
    chk(badCnt == 0, "R5 no ghost after re-enable", badCnt, 0);

    // R6: 4 -> 10
    addr = 7'd10;
    @(negedge clk);
    countBusy(n);
    chk(n == 6 * STEP, "R6 rise window", n, 6 * STEP);

    // R7: 10 -> 3
    addr = 7'd3;
    badCnt = 0;
    for (int d = 0; d < 5; d++) begin
      @(negedge clk);
      if (busy) badCnt++;
    end
    chk(badCnt == 0, "R7 fall keeps idle", badCnt, 0);

    // R8: change while busy
    addr = 7'd20;
    @(negedge clk);
    chk(errStb == 0, "R8 no error when idle", errStb, 0);
    repeat (3) @(negedge clk);
    addr = 7'd21;
    @(negedge clk);
    chk(errStb == 1, "R8 error on busy change", errStb, 1);
    @(negedge clk);
    chk(errStb == 0, "R8 strobe one cycle", errStb, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule